// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block runs the power-up and power-down sequence for a set of supply channels. Each channel is configured either as a soft-start rail or as a tracked rail. The analog parts of the supply path are outside the block. These are the gate ramp generators, the voltage comparators and the charge pump, and they appear here only as flag inputs. Per channel, the block reads four comparator results: source side above threshold, load side above threshold, gate fully ramped, and load side near ground. It answers with a gate-ramp enable and a gate clamp for each channel.

A power-up has three phases in a fixed order. The soft-start rails come up first. The tracked rails follow, and they ramp together. A shared lag line lets several controllers hold the tracked ramp while any one of their rails catches up. Three timers shape the sequence: a debounce on the board-inserted input, an optional limit on the total power-up time, and a delay before power-down. All three are counted in milliseconds from a cycle-count parameter, so a test can run with short intervals. An overrun of the power-up limit pulls the shared shutdown line low and holds it there until the power request is released and asserted again.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Power-up starts only while all of these hold at once:
  - the request input `pwr_req_n` is low;
  - the sensed shutdown line `fs_in_n` is high;
  - `seated_n` has stayed low without a break for SEAT_MS milliseconds.

  Until power-up starts, every clamp bit is 1 and every ramp bit is 0. Once it starts, the clamps release.
- R2: After power-up starts, the soft-start channels (`trk_cfg` bit 0) get their ramp enables only when the source-side flag of every soft-start channel is set and `pump_rdy` is set.
- R3: Tracked channels (`trk_cfg` bit 1) get no ramp enable until every soft-start channel shows both gate-full and load-side-ok.
- R4: Tracked ramp enables rise only after every tracked channel's source-side flag is set. When every tracked gate-full flag is set, `pwr_done_o` and `trk_done_o` go high and all ramp enables stay on.
- R5: With `limit_en` high, a power-up that has not reached done within LIMIT_MS milliseconds ends in shutdown. In that shutdown `fs_drv_o` is 1 (pulling the line low), all clamps are on and no ramp is enabled. With `limit_en` low, no such shutdown happens.
- R6: The shutdown latched by R5 holds whatever the flags do, for as long as `pwr_req_n` stays low. Only a release (high) followed by a new assertion (low) allows another power-up.
- R7: Raising `pwr_req_n` after done starts power-down, which proceeds in order:
  - all gates stay enabled for OFFDLY_MS milliseconds;
  - the ramp enable of the highest-numbered tracked channel then drops;
  - all gates are clamped once the near-ground flag of every tracked channel is set.
- R8: A low level on the sensed shutdown line clamps every gate in any power-up, power-down or done state. A high level on `seated_n` during done starts power-down.
- R9: In the tracked ramp phase, any of the following holds every tracked ramp enable low while the soft-start enables stay on:
  - the external lag line `lag_in_n` is low;
  - an own tracked channel reports lag.

  An own tracked channel reporting lag also sets `lag_drv_o`.
- R10: Reset leaves all clamps on and every other output low. A channel never has its ramp enable and its clamp on at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req_n | input | 1 | Power request, active low, asynchronous |
| seated_n | input | 1 | Board inserted, active low, asynchronous |
| fs_in_n | input | 1 | Sensed level of the shared shutdown line, asynchronous |
| lag_in_n | input | 1 | Sensed level of the shared lag line, asynchronous |
| limit_en | input | 1 | Enables the power-up time limit (static) |
| pump_rdy | input | 1 | Charge pump at its output level |
| trk_cfg | input | NCH | Per channel: 1 tracked, 0 soft-start (static) |
| bus_ok | input | NCH | Source side above threshold |
| card_ok | input | NCH | Load side above threshold |
| gate_full | input | NCH | Gate reached its full level |
| card_gnd | input | NCH | Load side near ground |
| ch_lag | input | NCH | Tracked channel behind the ramp reference |
| ramp_en_o | output | NCH | Gate ramp enable per channel |
| clamp_o | output | NCH | Gate clamp to ground per channel |
| fs_drv_o | output | 1 | 1 pulls the shared shutdown line low |
| lag_drv_o | output | 1 | 1 pulls the shared lag line low |
| trk_done_o | output | 1 | Tracking finished (done or powering down) |
| pwr_done_o | output | 1 | Power-up complete |

## Verification
Every input goes through two synchroniser flops before the state register, and the outputs are registered from the next state. A change on a pin therefore shows at the outputs on the third rising edge after it, and the timed intervals add their own length plus one edge. The bench drives inputs just after a falling edge. It then samples at least five cycles later for flag reactions. For the debounce, limit and power-down intervals it samples well before the computed due cycle and again well after it. The power-down sweep covers every non-empty tracked-channel pattern and computes the highest tracked bit itself.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [3:0] {
    S_OFF,
    S_SSWAIT,
    S_SSRAMP,
    S_TRKWAIT,
    S_TRKRAMP,
    S_ON,
    S_DNDLY,
    S_DNDIS,
    S_FAULT
  } pseq_st_e;
endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= INIT;
      q      <= INIT;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pseq_ivl.sv
module pseq_ivl #(
  parameter int TICK_CYC = 1000,
  parameter int MS       = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int SW = $clog2(TICK_CYC + 1);
  localparam int MW = $clog2(MS + 2);

  logic [SW-1:0] sub_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sub_q <= '0;
      ms_q  <= '0;
    end else if (ms_q != MW'(MS)) begin
      if (sub_q == SW'(TICK_CYC - 1)) begin
        sub_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign done = (ms_q == MW'(MS));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pseq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int TICK_CYC  = 100000,
  parameter int SEAT_MS   = 25,
  parameter int LIMIT_MS  = 200,
  parameter int OFFDLY_MS = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_req_n,
  input  logic           seated_n,
  input  logic           fs_in_n,
  input  logic           lag_in_n,
  input  logic           limit_en,
  input  logic           pump_rdy,
  input  logic [NCH-1:0] trk_cfg,
  input  logic [NCH-1:0] bus_ok,
  input  logic [NCH-1:0] card_ok,
  input  logic [NCH-1:0] gate_full,
  input  logic [NCH-1:0] card_gnd,
  input  logic [NCH-1:0] ch_lag,
  output logic [NCH-1:0] ramp_en_o,
  output logic [NCH-1:0] clamp_o,
  output logic           fs_drv_o,
  output logic           lag_drv_o,
  output logic           trk_done_o,
  output logic           pwr_done_o
);
  localparam int FW = 1 + 5 * NCH;

  // input synchronisers
  logic [3:0]    ctl_q;
  logic [FW-1:0] flg_q;
  logic req_s, seat_s, fs_s, lagl_s, pump_s;
  logic [NCH-1:0] bus_s, cok_s, gfull_s, gnd_s, chlag_s;

  pseq_sync #(.W(4), .INIT(4'hF)) ctl_sync_i (
    .clk(clk), .rst(rst),
    .d({pwr_req_n, seated_n, fs_in_n, lag_in_n}), .q(ctl_q));
  pseq_sync #(.W(FW), .INIT('0)) flg_sync_i (
    .clk(clk), .rst(rst),
    .d({pump_rdy, bus_ok, card_ok, gate_full, card_gnd, ch_lag}), .q(flg_q));

  assign {req_s, seat_s, fs_s, lagl_s} = ctl_q;
  assign {pump_s, bus_s, cok_s, gfull_s, gnd_s, chlag_s} = flg_q;

  pseq_st_e st_q, st_d;
  logic in_up;
  assign in_up = (st_q inside {S_SSWAIT, S_SSRAMP, S_TRKWAIT, S_TRKRAMP});

  // interval timers
  logic seat_ok, lim_hit, dly_done;
  pseq_ivl #(.TICK_CYC(TICK_CYC), .MS(SEAT_MS)) seat_ivl_i (
    .clk(clk), .rst(rst), .clr(seat_s), .done(seat_ok));
  pseq_ivl #(.TICK_CYC(TICK_CYC), .MS(LIMIT_MS)) lim_ivl_i (
    .clk(clk), .rst(rst), .clr(!in_up), .done(lim_hit));
  pseq_ivl #(.TICK_CYC(TICK_CYC), .MS(OFFDLY_MS)) dly_ivl_i (
    .clk(clk), .rst(rst), .clr(st_q != S_DNDLY), .done(dly_done));

  // per-channel conditions
  logic ss_src_ok, ss_fin, trk_src_ok, trk_fin, trk_gnd, own_lag, pause;
  logic [NCH-1:0] soft_m, hi_m;
  assign soft_m     = ~trk_cfg;
  assign ss_src_ok  = &(bus_s | trk_cfg);
  assign ss_fin     = &((gfull_s & cok_s) | trk_cfg);
  assign trk_src_ok = &(bus_s | soft_m);
  assign trk_fin    = &(gfull_s | soft_m);
  assign trk_gnd    = &(gnd_s | soft_m);
  assign own_lag    = |(chlag_s & trk_cfg);
  assign pause      = !lagl_s || own_lag;

  always_comb begin
    hi_m = '0;
    for (int i = 0; i < NCH; i++) begin
      if (trk_cfg[i]) begin
        hi_m    = '0;
        hi_m[i] = 1'b1;
      end
    end
  end

  // sequencing
  always_comb begin
    st_d = st_q;
    if (st_q == S_OFF) begin
      if (!req_s && fs_s && seat_ok) st_d = S_SSWAIT;
    end else if (st_q == S_FAULT) begin
      if (req_s) st_d = S_OFF;
    end else if (!fs_s) begin
      st_d = S_OFF;
    end else if (in_up && (req_s || seat_s)) begin
      st_d = S_OFF;
    end else if (in_up && limit_en && lim_hit) begin
      st_d = S_FAULT;
    end else begin
      case (st_q)
        S_SSWAIT:  if (ss_src_ok && pump_s) st_d = S_SSRAMP;
        S_SSRAMP:  if (ss_fin) st_d = S_TRKWAIT;
        S_TRKWAIT: if (trk_src_ok) st_d = S_TRKRAMP;
        S_TRKRAMP: if (trk_fin) st_d = S_ON;
        S_ON:      if (req_s || seat_s) st_d = S_DNDLY;
        S_DNDLY:   if (dly_done) st_d = S_DNDIS;
        S_DNDIS:   if (trk_gnd) st_d = S_OFF;
        default:   st_d = S_OFF;
      endcase
    end
  end

  // output decode from the next state
  logic [NCH-1:0] ramp_d, clamp_d;
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      always_comb begin
        case (st_d)
          S_SSRAMP, S_TRKWAIT: ramp_d[g] = soft_m[g];
          S_TRKRAMP:           ramp_d[g] = soft_m[g] || !pause;
          S_ON, S_DNDLY:       ramp_d[g] = 1'b1;
          S_DNDIS:             ramp_d[g] = !hi_m[g];
          default:             ramp_d[g] = 1'b0;
        endcase
        clamp_d[g] = (st_d == S_OFF) || (st_d == S_FAULT);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_OFF;
      ramp_en_o  <= '0;
      clamp_o    <= '1;
      fs_drv_o   <= 1'b0;
      lag_drv_o  <= 1'b0;
      trk_done_o <= 1'b0;
      pwr_done_o <= 1'b0;
    end else begin
      st_q       <= st_d;
      ramp_en_o  <= ramp_d;
      clamp_o    <= clamp_d;
      fs_drv_o   <= (st_d == S_FAULT);
      lag_drv_o  <= (st_d == S_TRKRAMP) && own_lag;
      trk_done_o <= (st_d inside {S_ON, S_DNDLY, S_DNDIS});
      pwr_done_o <= (st_d == S_ON);
    end
  end
endmodule

// File: rtl/pseq_chk.sv
module pseq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] trk_cfg,
  input logic [NCH-1:0] ramp_en_o,
  input logic [NCH-1:0] clamp_o,
  input logic           fs_drv_o,
  input logic           lag_drv_o,
  input logic           trk_done_o,
  input logic           pwr_done_o
);
  AST_NO_CLAMP_RAMP: assert property (@(posedge clk) disable iff (rst)
    (clamp_o & ramp_en_o) == '0); // R10

  AST_TRK_AFTER_SS: assert property (@(posedge clk) disable iff (rst)
    |(ramp_en_o & trk_cfg) |-> &(ramp_en_o | trk_cfg)); // R3

  AST_LAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    lag_drv_o |-> (ramp_en_o & trk_cfg) == '0); // R9

  AST_FAULT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    fs_drv_o |-> (&clamp_o && !pwr_done_o)); // R5

  AST_DONE_ORDER: assert property (@(posedge clk) disable iff (rst)
    pwr_done_o |-> (trk_done_o && &ramp_en_o)); // R4

  AST_DONE_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_done_o) && !clamp_o[0] |-> trk_done_o); // R7
endmodule

bind pwr_seq_ctrl pseq_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .trk_cfg(trk_cfg), .ramp_en_o(ramp_en_o),
  .clamp_o(clamp_o), .fs_drv_o(fs_drv_o), .lag_drv_o(lag_drv_o),
  .trk_done_o(trk_done_o), .pwr_done_o(pwr_done_o));

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_req_n = 1'b1, seated_n = 1'b1, fs_ext_n = 1'b1, lag_ext_n = 1'b1;
  logic limit_en = 1'b0, pump_rdy = 1'b0;
  logic [NCH-1:0] trk_cfg = 4'b1100;
  logic [NCH-1:0] bus_ok = '0, card_ok = '0, gate_full = '0, card_gnd = '0, ch_lag = '0;
  logic [NCH-1:0] ramp_en_o, clamp_o;
  logic fs_drv_o, lag_drv_o, trk_done_o, pwr_done_o;
  logic fs_line, lag_line;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign fs_line  = fs_ext_n & ~fs_drv_o;
  assign lag_line = lag_ext_n & ~lag_drv_o;

  pwr_seq_ctrl #(.NCH(NCH), .TICK_CYC(4), .SEAT_MS(3), .LIMIT_MS(30), .OFFDLY_MS(2)) dut_i (
    .clk(clk), .rst(rst), .pwr_req_n(pwr_req_n), .seated_n(seated_n),
    .fs_in_n(fs_line), .lag_in_n(lag_line), .limit_en(limit_en),
    .pump_rdy(pump_rdy), .trk_cfg(trk_cfg), .bus_ok(bus_ok),
    .card_ok(card_ok), .gate_full(gate_full), .card_gnd(card_gnd),
    .ch_lag(ch_lag), .ramp_en_o(ramp_en_o), .clamp_o(clamp_o),
    .fs_drv_o(fs_drv_o), .lag_drv_o(lag_drv_o), .trk_done_o(trk_done_o),
    .pwr_done_o(pwr_done_o));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic power_on();
    bus_ok = '1; card_ok = '1; gate_full = '1; card_gnd = '0; ch_lag = '0;
    pump_rdy = 1'b1; lag_ext_n = 1'b1; seated_n = 1'b0; pwr_req_n = 1'b0;
    step(30);
    chk("R4 power-up reaches done", pwr_done_o, 1);
  endtask

  task automatic power_off_check(input logic [NCH-1:0] cfg);
    logic [NCH-1:0] hi;
    hi = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cfg[i] && hi == '0) hi = NCH'(1) << i;
    end
    pwr_req_n = 1'b1;
    step(9);
    chk("R7 gates held during delay", ramp_en_o, 4'hF);
    step(6);
    chk("R7 highest tracked released", ramp_en_o, 4'hF & ~hi);
    chk("R7 trk_done kept in power-down", {pwr_done_o, trk_done_o}, 2'b01);
    chk("R7 no clamp before ground", clamp_o, 0);
    card_gnd = cfg;
    step(6);
    chk("R7 clamp once tracked rails at ground", clamp_o, 4'hF);
    chk("R7 ramps off after clamp", ramp_en_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R10 reset clamps", clamp_o, 4'hF);
    chk("R10 reset outputs low",
        {ramp_en_o, fs_drv_o, lag_drv_o, trk_done_o, pwr_done_o}, 0);
    rst = 1'b0;
    pwr_req_n = 1'b0;
    step(20);
    chk("R1 no start while not seated", clamp_o, 4'hF);
    seated_n = 1'b0;
    step(6);
    chk("R1 debounce not yet elapsed", clamp_o, 4'hF);
    step(20);
    chk("R1 start after debounce", clamp_o, 0);
    chk("R2 no ramp before source ok", ramp_en_o, 0);
    bus_ok = 4'b0011;
    step(8);
    chk("R2 no ramp without pump", ramp_en_o, 0);
    pump_rdy = 1'b1;
    step(6);
    chk("R2 soft channels ramp", ramp_en_o, 4'b0011);
    gate_full = 4'b0011; card_ok = 4'b0001;
    step(6);
    chk("R3 tracked wait for soft load side", ramp_en_o, 4'b0011);
    card_ok = 4'b0011;
    step(6);
    chk("R4 tracked wait for source ok", ramp_en_o, 4'b0011);
    bus_ok = 4'hF;
    step(6);
    chk("R4 tracked ramp", ramp_en_o, 4'hF);
    ch_lag = 4'b0100;
    step(6);
    chk("R9 own lag pauses tracked", ramp_en_o, 4'b0011);
    chk("R9 own lag drives line", lag_drv_o, 1);
    ch_lag = '0; lag_ext_n = 1'b0;
    step(6);
    chk("R9 external lag pauses tracked", ramp_en_o, 4'b0011);
    chk("R9 no drive on external lag", lag_drv_o, 0);
    lag_ext_n = 1'b1;
    step(6);
    chk("R9 resume after lag", ramp_en_o, 4'hF);
    chk("R4 not done before gates full", pwr_done_o, 0);
    gate_full = 4'hF; card_ok = 4'hF;
    step(6);
    chk("R4 done flags", {pwr_done_o, trk_done_o}, 2'b11);

    // power-down sweep over tracked-channel patterns
    power_off_check(4'b1100);
    for (int c = 1; c < 16; c++) begin
      trk_cfg = 4'(c);
      power_on();
      power_off_check(4'(c));
    end

    // power-up time limit
    trk_cfg = 4'b1100; limit_en = 1'b1;
    bus_ok = '0; pump_rdy = 1'b0; card_gnd = '0;
    pwr_req_n = 1'b0;
    step(60);
    chk("R5 no shutdown before limit", {fs_drv_o, clamp_o}, 0);
    step(100);
    chk("R5 shutdown after limit", fs_drv_o, 1);
    chk("R5 clamps on shutdown", clamp_o, 4'hF);
    bus_ok = '1; card_ok = '1; gate_full = '1; pump_rdy = 1'b1;
    step(20);
    chk("R6 shutdown held while request low", {fs_drv_o, pwr_done_o}, 2'b10);
    pwr_req_n = 1'b1;
    step(8);
    chk("R6 release on request high", {fs_drv_o, clamp_o}, 5'h0F);
    pwr_req_n = 1'b0;
    step(10);
    chk("R6 new power-up after toggle", pwr_done_o, 1);
    pwr_req_n = 1'b1; card_gnd = '1;
    step(25);
    chk("R7 back off", clamp_o, 4'hF);

    limit_en = 1'b0; bus_ok = '0; pump_rdy = 1'b0; card_gnd = '0;
    pwr_req_n = 1'b0;
    step(200);
    chk("R5 no shutdown when limit disabled", {fs_drv_o, clamp_o}, 0);

    // external shutdown line
    fs_ext_n = 1'b0;
    step(5);
    chk("R8 external shutdown clamps", clamp_o, 4'hF);
    step(20);
    chk("R8 no start while line low", clamp_o, 4'hF);
    fs_ext_n = 1'b1;
    power_on();
    card_gnd = '1;
    seated_n = 1'b1;
    step(25);
    chk("R8 unseat powers down", {pwr_done_o, clamp_o}, 5'h0F);
    step(40);
    chk("R1 no restart while unseated", clamp_o, 4'hF);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule